// File: doc/BRIEF.md
# Dual Simultaneous-Sampling ADC Reader

This block is the host side of a serial link to a successive-approximation converter with two converters, each fed by a three-way input selector. A single start request runs one conversion frame. The block first places the channel-pair address and the input-range line on the converter pins. It then pulls chip select low, which samples both inputs at the same instant. Next it runs the serial clock and shifts in both results. There is no pipeline delay, so the data read always belongs to the sample just taken.

Results arrive in one of two ways, chosen per frame. In separate-line mode, each converter has its own data line and the frame is 16 serial clocks long. In shared-line mode, both results travel on data line A, with converter A's slot first and converter B's slot second, over 32 serial clocks. Each 16-bit slot holds two leading zeros, then 12 data bits MSB first, then two don't-care bits. Data is sampled on the falling edge of the serial clock.

The serial clock is the system clock divided by 2·`CLK_DIV`. When a frame ends, a guard counter keeps chip select high for a minimum quiet time before another start is taken. Both results update together in the cycle chip select rises. They are tagged with the channel-pair address and the output coding, and a one-cycle done strobe marks the update.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_sclk` are 1, `done` is 0, both results, `res_chan` and `res_twos` are 0, and `ready` is 1.
- R2: A start is taken only while `ready` is 1. The address and range of that start appear on `adc_addr`/`adc_range` at least one cycle before `adc_cs_n` falls, and they stay unchanged for as long as `adc_cs_n` is low.
- R3: `adc_sclk` is 1 whenever `adc_cs_n` is 1. The first falling edge of `adc_sclk` comes at least `SETUP_CYC` system cycles after `adc_cs_n` falls.
- R4: Each low phase and each high phase of `adc_sclk` inside a frame lasts exactly `CLK_DIV` system cycles, so a frame with N clocks has N·`CLK_DIV` low cycles.
- R5: In separate-line mode (`one_line`=0), a frame has exactly 16 falling edges of `adc_sclk`. Counting the bit sampled at the first fall as bit 0, bits 2..13 of `adc_dout_a` (MSB first) form `res_a`, and bits 2..13 of `adc_dout_b` form `res_b`.
- R6: In shared-line mode (`one_line`=1), a frame has exactly 32 falls. On `adc_dout_a`, bits 2..13 form `res_a` and bits 18..29 form `res_b`. `adc_dout_b` has no effect on either result.
- R7: `done` is high for exactly one cycle, and it is the cycle in which `adc_cs_n` returns to 1. Both results and both tags change in that cycle and hold until the next `done`.
- R8: `res_chan` equals the address taken with the start. `res_twos` is 0 (straight binary) only when `single_ended`=1 and `range_sel`=0; in every other case it is 1 (two's complement).
- R9: After `adc_cs_n` rises, it stays high for at least `QUIET_CYC` cycles. A start that comes while `ready` is 0 is dropped, not queued.
- R10: Changing `pair_addr`, `range_sel`, `single_ended` or `one_line`, or pulsing `start`, while a frame runs does not change that frame's pins, length, results or tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion frame |
| pair_addr | input | 3 | Channel-pair address for the frame |
| range_sel | input | 1 | 0: zero-to-reference range, 1: double range |
| single_ended | input | 1 | 1: single-ended inputs, 0: differential |
| one_line | input | 1 | 1: both results on data line A |
| ready | output | 1 | Idle and quiet time elapsed; start is taken |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_addr | output | 3 | Address lines to the converter |
| adc_range | output | 1 | Range line to the converter |
| adc_dout_a | input | 1 | Serial data from converter A |
| adc_dout_b | input | 1 | Serial data from converter B |
| done | output | 1 | One-cycle strobe: results updated |
| res_a | output | 12 | Result of converter A |
| res_b | output | 12 | Result of converter B |
| res_chan | output | 3 | Address the results belong to |
| res_twos | output | 1 | 1: two's complement, 0: straight binary |

## Verification
Two events can land on the same edge. One is the end of a frame, when chip select rises and the results load. The other is a start request that is still held high at that moment. The bench provokes this by holding `start` high through a frame, so the guard counter alone decides when the second chip-select fall happens. The measured high gap is then checked against `QUIET_CYC`. A second collision is a start pulse or input change that arrives mid-frame; the bench checks that this leaves the address pins, the frame length and the tagged results of the running frame untouched.

// File: rtl/dadc_pkg.sv
package dadc_pkg;

  localparam int DADC_ADDR_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_SHIFT
  } dadc_state_t;

  typedef struct packed {
    logic [DADC_ADDR_W-1:0] chan;
    logic                   twos;
    logic                   one_line;
  } dadc_cfg_t;

  // straight binary only for single-ended inputs on the narrow range
  function automatic logic dadc_is_twos(input logic se, input logic wide);
    return !(se && !wide);
  endfunction

endpackage

// File: rtl/dadc_sclk_gen.sv
module dadc_sclk_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // tick is high in the cycle whose closing edge toggles sclk
  assign fall_tick = run && sclk && (cnt == LAST);
  assign rise_tick = run && !sclk && (cnt == LAST);

endmodule

// File: rtl/dadc_lane.sv
module dadc_lane #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/dadc_gap_timer.sv
module dadc_gap_timer #(
  parameter int QUIET_CYC = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic gap_ok
);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam logic [QW-1:0] QLOAD = QW'(QUIET_CYC);

  logic [QW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)             left <= '0;
    else if (load)       left <= QLOAD;
    else if (left != '0) left <= left - 1'b1;
  end

  assign gap_ok = (left == '0);
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import dadc_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int LEAD_BITS = 2,
  parameter int TAIL_BITS = 2,
  parameter int CLK_DIV   = 2,
  parameter int SETUP_CYC = 3,
  parameter int QUIET_CYC = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [DADC_ADDR_W-1:0] pair_addr,
  input  logic                   range_sel,
  input  logic                   single_ended,
  input  logic                   one_line,
  output logic                   ready,
  output logic                   adc_cs_n,
  output logic                   adc_sclk,
  output logic [DADC_ADDR_W-1:0] adc_addr,
  output logic                   adc_range,
  input  logic                   adc_dout_a,
  input  logic                   adc_dout_b,
  output logic                   done,
  output logic [DATA_W-1:0]      res_a,
  output logic [DATA_W-1:0]      res_b,
  output logic [DADC_ADDR_W-1:0] res_chan,
  output logic                   res_twos
);
  localparam int FRAME_W = LEAD_BITS + DATA_W + TAIL_BITS;
  localparam int BCW     = $clog2(2 * FRAME_W + 1);
  localparam int SCW     = (SETUP_CYC > 1) ? $clog2(SETUP_CYC + 1) : 1;
  localparam int QW      = $clog2(QUIET_CYC + 1);
  localparam logic [BCW-1:0] NCLK_SEP  = BCW'(FRAME_W);
  localparam logic [BCW-1:0] NCLK_ONE  = BCW'(2 * FRAME_W);
  localparam logic [BCW-1:0] WIN0_LO   = BCW'(LEAD_BITS);
  localparam logic [BCW-1:0] WIN0_HI   = BCW'(LEAD_BITS + DATA_W);
  localparam logic [BCW-1:0] WIN1_LO   = BCW'(FRAME_W + LEAD_BITS);
  localparam logic [BCW-1:0] WIN1_HI   = BCW'(FRAME_W + LEAD_BITS + DATA_W);
  localparam logic [SCW-1:0] SETUP_END = SCW'(SETUP_CYC - 1);

  dadc_state_t           state;
  dadc_cfg_t             cfg;
  logic [BCW-1:0]        fall_cnt;
  logic [SCW-1:0]        setup_cnt;
  logic                  fall_tick, rise_tick, run, gap_ok;
  logic                  in_win, frame_end;
  logic [BCW-1:0]        nclk;
  logic [2*DATA_W-1:0]   lane_a;
  logic [DATA_W-1:0]     lane_b;
  logic [DATA_W-1:0]     word_a, word_b;

  assign run       = (state == ST_SHIFT);
  assign nclk      = cfg.one_line ? NCLK_ONE : NCLK_SEP;
  assign frame_end = run && rise_tick && (fall_cnt == nclk);
  assign ready     = (state == ST_IDLE) && gap_ok;

  // only data slots enter the lanes; lead and tail bits are skipped
  assign in_win = ((fall_cnt >= WIN0_LO) && (fall_cnt < WIN0_HI)) ||
                  (cfg.one_line && (fall_cnt >= WIN1_LO) && (fall_cnt < WIN1_HI));

  dadc_sclk_gen #(.DIV(CLK_DIV)) u_sclk (
    .clk(clk), .rst(rst), .run(run),
    .sclk(adc_sclk), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  dadc_lane #(.W(2 * DATA_W)) u_lane_a (
    .clk(clk), .rst(rst), .clr(state == ST_ADDR),
    .en(fall_tick && in_win), .din(adc_dout_a), .q(lane_a)
  );

  dadc_lane #(.W(DATA_W)) u_lane_b (
    .clk(clk), .rst(rst), .clr(state == ST_ADDR),
    .en(fall_tick && in_win && !cfg.one_line), .din(adc_dout_b), .q(lane_b)
  );

  dadc_gap_timer #(.QUIET_CYC(QUIET_CYC)) u_gap (
    .clk(clk), .rst(rst), .load(frame_end), .gap_ok(gap_ok)
  );

  assign word_a = cfg.one_line ? lane_a[2*DATA_W-1:DATA_W] : lane_a[DATA_W-1:0];
  assign word_b = cfg.one_line ? lane_a[DATA_W-1:0]        : lane_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cfg       <= '0;
      adc_cs_n  <= 1'b1;
      adc_addr  <= '0;
      adc_range <= 1'b0;
      fall_cnt  <= '0;
      setup_cnt <= '0;
      done      <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
      res_chan  <= '0;
      res_twos  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start && gap_ok) begin
          adc_addr     <= pair_addr;
          adc_range    <= range_sel;
          cfg.chan     <= pair_addr;
          cfg.twos     <= dadc_is_twos(single_ended, range_sel);
          cfg.one_line <= one_line;
          state        <= ST_ADDR;
        end
        ST_ADDR: begin
          adc_cs_n  <= 1'b0;
          setup_cnt <= '0;
          fall_cnt  <= '0;
          state     <= ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_cnt == SETUP_END) state <= ST_SHIFT;
          else                        setup_cnt <= setup_cnt + 1'b1;
        end
        ST_SHIFT: begin
          if (fall_tick) fall_cnt <= fall_cnt + 1'b1;
          if (frame_end) begin
            adc_cs_n <= 1'b1;
            done     <= 1'b1;
            res_a    <= word_a;
            res_b    <= word_b;
            res_chan <= cfg.chan;
            res_twos <= cfg.twos;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertion-side observers ----------------
  logic           chk_sclk_d;
  logic [BCW-1:0] chk_falls;
  logic [QW-1:0]  chk_gap;
  logic [SCW-1:0] chk_setup;
  logic           chk_fall_seen;

  assign chk_fall_seen = chk_sclk_d && !adc_sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_sclk_d <= 1'b1;
      chk_falls  <= '0;
      chk_gap    <= QW'(QUIET_CYC);
      chk_setup  <= '0;
    end else begin
      chk_sclk_d <= adc_sclk;
      if (adc_cs_n) chk_falls <= '0;
      else if (chk_fall_seen) chk_falls <= chk_falls + 1'b1;
      if (!adc_cs_n) chk_gap <= '0;
      else if (chk_gap != QW'(QUIET_CYC)) chk_gap <= chk_gap + 1'b1;
      if (adc_cs_n) chk_setup <= '0;
      else if (chk_setup != SCW'(SETUP_CYC)) chk_setup <= chk_setup + 1'b1;
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> ($stable(adc_addr) && $stable(adc_range)));  // R2
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk);  // R3
  AST_CS_SETUP: assert property (@(posedge clk) disable iff (rst)
    (!adc_cs_n && chk_fall_seen && chk_falls == '0) |-> (chk_setup >= SCW'(SETUP_CYC)));  // R3
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> (chk_falls == nclk));  // R5
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7
  AST_DONE_AT_CS: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> done);  // R7
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> (chk_gap >= QW'(QUIET_CYC)));  // R9

endmodule

// File: tb/dual_adc_reader_bench.sv
module dual_adc_reader_bench;
  localparam int DW = 12, DIV = 2, SETC = 3, QUI = 9;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] pair_addr = '0;
  logic range_sel = 1'b0, single_ended = 1'b0, one_line = 1'b0;
  logic dout_a = 1'b0, dout_b = 1'b0;
  logic ready, adc_cs_n, adc_sclk, adc_range, done, res_twos;
  logic [2:0] adc_addr, res_chan;
  logic [DW-1:0] res_a, res_b;

  always #2 clk = ~clk;

  dual_adc_reader #(.DATA_W(DW), .CLK_DIV(DIV), .SETUP_CYC(SETC), .QUIET_CYC(QUI)) u_dual_adc_reader (
    .clk(clk), .rst(rst), .start(start), .pair_addr(pair_addr), .range_sel(range_sel),
    .single_ended(single_ended), .one_line(one_line), .ready(ready), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_addr(adc_addr), .adc_range(adc_range), .adc_dout_a(dout_a),
    .adc_dout_b(dout_b), .done(done), .res_a(res_a), .res_b(res_b), .res_chan(res_chan),
    .res_twos(res_twos)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: new bit after each sclk rise, first bit at cs fall
  logic [31:0] fr_a = '0, fr_b = '0;
  int bidx = 0;
  always @(negedge adc_cs_n) begin
    bidx = 0; dout_a = fr_a[31]; dout_b = fr_b[31];
  end
  always @(posedge adc_sclk) if (!adc_cs_n && bidx < 31) begin
    bidx++; dout_a = fr_a[31 - bidx]; dout_b = fr_b[31 - bidx];
  end

  // pin monitor
  int cyc = 0, frames = 0, falls = 0, lows = 0, hi_run = 100, gap_seen = 0;
  int setup_seen = 0, cs_fall_cyc = 0;
  logic [2:0] fa = '0, prev_addr = '0;
  logic fr_rng = 1'b0, prev_rng = 1'b0, prev_cs = 1'b1;
  bit moved = 0, pre_ok = 1;

  always @(posedge clk) cyc++;
  always @(negedge adc_cs_n) begin frames++; falls = 0; cs_fall_cyc = cyc; end
  always @(negedge adc_sclk) if (!adc_cs_n) begin
    if (falls == 0) setup_seen = cyc - cs_fall_cyc;
    falls++;
  end
  always @(negedge clk) begin
    if (prev_cs && !adc_cs_n) begin
      fa = adc_addr; fr_rng = adc_range; moved = 0; lows = 0; gap_seen = hi_run;
      pre_ok = (adc_addr == prev_addr) && (adc_range == prev_rng);
    end
    if (!adc_cs_n) begin
      if (adc_addr != fa || adc_range != fr_rng) moved = 1;
      if (!adc_sclk) lows++;
      hi_run = 0;
    end else hi_run++;
    prev_cs = adc_cs_n; prev_addr = adc_addr; prev_rng = adc_range;
  end

  task automatic t_reset();
    chk(adc_cs_n == 1, "R1 cs_n", adc_cs_n, 1);
    chk(adc_sclk == 1, "R1 sclk", adc_sclk, 1);
    chk(done == 0, "R1 done", done, 0);
    chk(res_a == 0 && res_b == 0, "R1 results", {res_a, res_b}, 0);
    chk(res_chan == 0 && res_twos == 0, "R1 tags", {res_chan, res_twos}, 0);
    chk(ready == 1, "R1 ready", ready, 1);
  endtask

  task automatic run_frame(input logic [2:0] a, input logic r, input logic se, input logic one,
                           input logic [11:0] va, input logic [11:0] vb, input bit disturb);
    int nclk = one ? 32 : 16;
    int f0;
    bit got = 0;
    logic etw = !(se && !r);
    fr_a = one ? {2'b00, va, 2'b10, 2'b00, vb, 2'b10} : {2'b00, va, 2'b10, 16'hB3C7};
    fr_b = one ? 32'h5A3C_96E1 : {2'b00, vb, 2'b01, 16'h7E81};
    while (!ready) @(negedge clk);
    pair_addr = a; range_sel = r; single_ended = se; one_line = one; start = 1; f0 = frames;
    @(negedge clk); start = 0;
    if (disturb) begin  // R10 inputs moved and start pulsed mid-frame
      repeat (6) @(negedge clk);
      pair_addr = ~a; range_sel = ~r; single_ended = ~se; one_line = ~one; start = 1;
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 1000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    chk(got, "R7 done seen", got, 1);
    chk(adc_cs_n == 1, "R7 cs high with done", adc_cs_n, 1);
    chk(res_a == va, one ? "R6 res_a shared line" : "R5 res_a", res_a, va);
    chk(res_b == vb, one ? "R6 res_b shared line" : "R5 res_b", res_b, vb);
    chk(falls == nclk, one ? "R6 clock count" : "R5 clock count", falls, nclk);
    chk(lows == nclk * DIV, "R4 sclk low cycles", lows, nclk * DIV);
    chk(setup_seen >= SETC, "R3 cs to first fall", setup_seen, SETC);
    chk(fa == a && fr_rng == r, "R2 pins at cs fall", {fa, fr_rng}, {a, r});
    chk(pre_ok && !moved, "R2 pins stable", {pre_ok, moved}, 2);
    chk(res_chan == a, "R8 channel tag", res_chan, a);
    chk(res_twos == etw, "R8 coding tag", res_twos, etw);
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
    chk(res_a == va && res_b == vb, "R7 results held", {res_a, res_b}, {va, vb});
    chk(frames == f0 + 1, disturb ? "R10 one frame only" : "R9 one frame only", frames, f0 + 1);
    chk(adc_sclk == 1, "R3 sclk idle", adc_sclk, 1);
  endtask

  task automatic t_quiet();
    int f0;
    run_frame(3'd3, 1'b0, 1'b0, 1'b0, 12'h6D2, 12'h2B9, 0);
    chk(ready == 0, "R9 not ready in gap", ready, 0);
    f0 = frames;
    start = 1; @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    chk(frames == f0, "R9 start in gap dropped", frames, f0);
    chk(adc_cs_n == 1 && ready == 1, "R9 idle after gap", {adc_cs_n, ready}, 3);
  endtask

  task automatic t_b2b();
    int seen = 0;
    fr_a = {2'b00, 12'hC01, 2'b10, 16'hB3C7};
    fr_b = {2'b00, 12'h3FE, 2'b01, 16'h7E81};
    while (!ready) @(negedge clk);
    pair_addr = 3'd5; range_sel = 1; single_ended = 0; one_line = 0; start = 1;
    for (int i = 0; i < 2000 && seen < 2; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    start = 0;
    chk(seen == 2, "R9 held start gives frames", seen, 2);
    chk(gap_seen >= QUI, "R9 quiet gap held start", gap_seen, QUI);
    chk(res_a == 12'hC01 && res_b == 12'h3FE, "R5 back-to-back results", {res_a, res_b}, {12'hC01, 12'h3FE});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    run_frame(3'd0, 1'b0, 1'b1, 1'b0, 12'hABC, 12'h123, 0);
    run_frame(3'd5, 1'b1, 1'b1, 1'b0, 12'hFFF, 12'h000, 0);
    run_frame(3'd2, 1'b0, 1'b0, 1'b0, 12'h800, 12'h7FF, 0);
    run_frame(3'd7, 1'b1, 1'b0, 1'b0, 12'h555, 12'hAAA, 0);
    run_frame(3'd1, 1'b0, 1'b1, 1'b1, 12'h9E3, 12'h16C, 0);
    run_frame(3'd6, 1'b1, 1'b0, 1'b1, 12'h001, 12'hFFE, 0);
    run_frame(3'd4, 1'b1, 1'b1, 1'b0, 12'h3A5, 12'hC5A, 1);
    run_frame(3'd2, 1'b0, 1'b1, 1'b1, 12'h7E4, 12'h81B, 1);
    t_quiet();
    t_b2b();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule